// File: doc/BRIEF.md
# Sound-Generator Register Bus Interface

This block holds the sixteen byte-wide control registers of a programmable sound generator and places them behind a four-byte processor bus window. A processor first writes a register number to the select port, then reads or writes the chosen register through the data port. Address bit 1 decides which port is meant. Address bit 0 marks a shadow alias of the same port, and a shadow alias accepts byte-size writes only.

Each register keeps only the bits that its function defines. A separate read-back latch decides what a read of offset 0 returns. Right after a data write, the read returns the whole byte just written. After a reselect, it returns the stored, masked value of the newly chosen register. The full register image is driven out for downstream tone and port logic. A write to any of the sound registers is also announced on a one-cycle strobe that carries the index and the masked value.

Top module: `snd_regbank`

## Requirements
- R1: The select latch keeps all 8 written bits. A selection value of 16 (0x10) or more addresses no register, so 0x13 does not alias register 3.
- R2: While the selection is 16 or more, data writes change no register and raise no strobe, and a read of offset 0 returns 0xFF.
- R3: Address bit 1 picks the port: offsets 0 and 1 reach the select port and offsets 2 and 3 reach the data port. A data write through offset 2 takes effect for both byte and wider accesses.
- R4: Reads at offsets 1, 2 and 3 always return 0xFF.
- R5: A write to a shadow alias (offset 1 or 3) takes effect only when `byte_acc` is 1. Wider writes to these offsets are dropped and leave the selection and the registers unchanged.
- R6: Registers 1, 3, 5 and 13 store only bits 3:0. Registers 6, 8, 9 and 10 store only bits 4:0. All other registers store all 8 bits.
- R7: After a data write, a read of offset 0 without a reselect returns the unmasked byte just written. After a select write to register n (n < 16), a read of offset 0 returns the masked stored value of register n.
- R8: Reset is synchronous and active-low. It clears every register to 0 except register 14, which becomes 0xFF. It also clears the selection, the read-back latch and `rdata` to 0.
- R9: A data write to register 0 through 13 raises `snd_wr_stb` for exactly the one cycle after the write edge, with `snd_wr_idx` set to the register number and `snd_wr_val` set to the masked value. Writes to registers 14 and 15 raise no strobe.
- R10: `rdata` is registered. It shows the read result from the clock edge that samples the read request, and it holds its value while no read is made.
- R11: `reg_image` bits [8*n+7:8*n] show the stored value of register n, and they update at the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Access request for the window |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Byte offset in the window |
| byte_acc | input | 1 | 1 = the access is byte-size |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| reg_image | output | 128 | Stored values of all sixteen registers |
| snd_wr_stb | output | 1 | Pulses once per sound-register write |
| snd_wr_idx | output | 4 | Index of the sound register written |
| snd_wr_val | output | 8 | Masked value written |

## Verification
The hardest case to reach from the ports is the read-back latch disagreeing with the stored register. This happens only on a masked register that has just received a byte with bits above its mask, and only before any reselect. The stimulus writes 0xAB to register 1 and reads 0xAB back. It then reselects the same register and expects 0x0B. A second case is a wide write to a shadow alias that arrives after a data write. The following read must still show the old read-back byte, which proves that the selection was left unchanged.

// File: rtl/snd_regbank_pkg.sv
// Package: shared sizes and per-register constants of the register bank.
// Assumes sixteen byte registers indexed by the low nibble of the selection.
package snd_regbank_pkg;
    localparam int DW      = 8;
    localparam int NREG    = 16;
    localparam int IDXW    = $clog2(NREG);
    localparam int NSND    = 14;
    localparam int PORTA   = 14;
    localparam int IMGW    = NREG * DW;

    // Bits a register keeps when written.
    function automatic logic [DW-1:0] keep_mask(input int idx);
        case (idx)
            1, 3, 5, 13: keep_mask = 8'h0F;
            6, 8, 9, 10: keep_mask = 8'h1F;
            default:     keep_mask = 8'hFF;
        endcase
    endfunction

    // Value a register takes on reset.
    function automatic logic [DW-1:0] reset_val(input int idx);
        reset_val = (idx == PORTA) ? 8'hFF : 8'h00;
    endfunction
endpackage

// File: rtl/snd_bus_decode.sv
// Module: snd_bus_decode
// Turns one bus request into a select write, a data write or a read.
// Assumes at most one request per cycle. A shadow-alias write is kept
// only when it is byte-size.
module snd_bus_decode (
    input  logic       cs,
    input  logic       we,
    input  logic [1:0] addr,
    input  logic       byte_acc,
    output logic       sel_we,
    output logic       dat_we,
    output logic       rd_en,
    output logic       rd_ofs0
);
    logic wr_ok;

    // Qualify writes: a shadow alias needs a byte-size access.
    always_comb begin
        wr_ok   = cs && we && (!addr[0] || byte_acc);
        sel_we  = wr_ok && !addr[1];
        dat_we  = wr_ok && addr[1];
        rd_en   = cs && !we;
        rd_ofs0 = (addr == 2'd0);
    end
endmodule

// File: rtl/snd_reg_store.sv
// Module: snd_reg_store
// Holds the selection latch, the read-back latch and the sixteen masked
// registers, and announces sound-register writes on a strobe.
// Assumes sel_we and dat_we are never high together.
module snd_reg_store
    import snd_regbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_we,
    input  logic            dat_we,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   sel_q,
    output logic [DW-1:0]   rb_q,
    output logic [IMGW-1:0] image,
    output logic            stb,
    output logic [IDXW-1:0] stb_idx,
    output logic [DW-1:0]   stb_val
);
    logic [DW-1:0] regs [NREG];
    logic          sel_ok;
    logic          wsel_ok;
    logic          past_valid;

    assign sel_ok  = (sel_q[DW-1:IDXW] == '0);
    assign wsel_ok = (wdata[DW-1:IDXW] == '0);

    // Selection latch: keeps every written bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_we) sel_q <= wdata;
    end

    // Read-back latch: masked value on reselect, raw byte on data write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rb_q <= '0;
        else if (sel_we)
            rb_q <= wsel_ok ? regs[wdata[IDXW-1:0]] : 8'hFF;
        else if (dat_we && sel_ok)
            rb_q <= wdata;
    end

    // One storage register per index, each with its own mask and reset value.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] KM = keep_mask(g);
        localparam logic [DW-1:0] RV = reset_val(g);

        // Store the masked byte when this index is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= RV;
            else if (dat_we && sel_ok && (sel_q[IDXW-1:0] == IDXW'(g)))
                regs[g] <= wdata & KM;
        end

        assign image[g*DW +: DW] = regs[g];

        if (KM != 8'hFF) begin : g_chk
            AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                (regs[g] & ~KM) == '0) else $error("masked bits set"); // R6
        end
    end

    // Write strobe towards the sound-rendering side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb     <= 1'b0;
            stb_idx <= '0;
            stb_val <= '0;
        end else begin
            stb     <= dat_we && sel_ok && (sel_q[IDXW-1:0] < IDXW'(NSND));
            stb_idx <= sel_q[IDXW-1:0];
            stb_val <= wdata & keep_mask(int'(sel_q[IDXW-1:0]));
        end
    end

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    AST_OOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(dat_we && !sel_ok)) |-> (image == $past(image)))
        else $error("out-of-range write changed a register"); // R2
endmodule

// File: rtl/snd_rd_port.sv
// Module: snd_rd_port
// Registers read data. Only offset 0 with a valid selection returns the
// read-back latch; every other read returns 0xFF.
// Assumes rd_en is high for one cycle per read.
module snd_rd_port
    import snd_regbank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          rd_ofs0,
    input  logic [DW-1:0] sel_q,
    input  logic [DW-1:0] rb_q,
    output logic [DW-1:0] rdata
);
    logic past_valid;

    // Capture the read result, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= (rd_ofs0 && (sel_q[DW-1:IDXW] == '0)) ? rb_q : 8'hFF;
    end

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    AST_SHADOW_RD_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(rd_en && !rd_ofs0)) |-> (rdata == 8'hFF))
        else $error("non-zero offset read not 0xFF"); // R4
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && !$past(rd_en)) |-> $stable(rdata))
        else $error("rdata moved without a read"); // R10
endmodule

// File: rtl/snd_regbank.sv
// Module: snd_regbank (top)
// Bus window for the sound-generator register bank: decode, storage and
// registered read port.
// Assumes a single bus master and a single clock domain.
module snd_regbank
    import snd_regbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs,
    input  logic            we,
    input  logic [1:0]      addr,
    input  logic            byte_acc,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic [IMGW-1:0] reg_image,
    output logic            snd_wr_stb,
    output logic [IDXW-1:0] snd_wr_idx,
    output logic [DW-1:0]   snd_wr_val
);
    logic          sel_we, dat_we, rd_en, rd_ofs0;
    logic [DW-1:0] sel_q, rb_q;

    snd_bus_decode u_dec (
        .cs(cs), .we(we), .addr(addr), .byte_acc(byte_acc),
        .sel_we(sel_we), .dat_we(dat_we), .rd_en(rd_en), .rd_ofs0(rd_ofs0)
    );

    snd_reg_store u_store (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .dat_we(dat_we),
        .wdata(wdata), .sel_q(sel_q), .rb_q(rb_q), .image(reg_image),
        .stb(snd_wr_stb), .stb_idx(snd_wr_idx), .stb_val(snd_wr_val)
    );

    snd_rd_port u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_ofs0(rd_ofs0),
        .sel_q(sel_q), .rb_q(rb_q), .rdata(rdata)
    );

    AST_WIDE_SHADOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && addr[0] && !byte_acc) |-> (!sel_we && !dat_we))
        else $error("wide shadow write accepted"); // R5
    AST_STB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        snd_wr_stb |-> (snd_wr_idx < IDXW'(NSND)))
        else $error("strobe for non-sound register"); // R9
endmodule

// File: tb/sim_snd_regbank.sv
module sim_snd_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs = 1'b0, we = 1'b0, byte_acc = 1'b0;
    logic [1:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic [127:0] reg_image;
    logic         snd_wr_stb;
    logic [3:0]   snd_wr_idx;
    logic [7:0]   snd_wr_val;

    int checks = 0;
    int errors = 0;
    logic       s_stb;
    logic [3:0] s_idx;
    logic [7:0] s_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    snd_regbank u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
        .byte_acc(byte_acc), .wdata(wdata), .rdata(rdata),
        .reg_image(reg_image), .snd_wr_stb(snd_wr_stb),
        .snd_wr_idx(snd_wr_idx), .snd_wr_val(snd_wr_val)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write; captures the strobe outputs one cycle after the write edge.
    task automatic bus_wr(input logic [1:0] a, input logic bsz, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; byte_acc = bsz; wdata = d;
        @(posedge clk);
        @(negedge clk);
        s_stb = snd_wr_stb; s_idx = snd_wr_idx; s_val = snd_wr_val;
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a; byte_acc = 1'b1;
        @(posedge clk);
        @(negedge clk);
        d = rdata;
        cs = 1'b0;
    endtask

    function automatic logic [7:0] img(input int n);
        return reg_image[n*8 +: 8];
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        for (int i = 0; i < 16; i++)
            check("R8 reset image", img(i), (i == 14) ? 8'hFF : 8'h00);
        check("R8 rdata after reset", rdata, 8'h00);
        check("R8 no strobe", snd_wr_stb, 1'b0);
        bus_rd(2'd0, d);
        check("R8 read reg0 via reset selection", d, 8'h00);
    endtask

    task automatic t_mask_readback();
        logic [7:0] d;
        bus_wr(2'd0, 1'b1, 8'd1);
        bus_wr(2'd2, 1'b1, 8'hAB);
        check("R9 strobe", s_stb, 1'b1);
        check("R9 strobe idx", s_idx, 4'd1);
        check("R9 strobe masked val", s_val, 8'h0B);
        check("R11 image reg1", img(1), 8'h0B);
        @(negedge clk);
        check("R9 strobe one cycle", snd_wr_stb, 1'b0);
        bus_rd(2'd0, d);
        check("R7 unmasked after data write", d, 8'hAB);
        bus_wr(2'd0, 1'b1, 8'd1);
        bus_rd(2'd0, d);
        check("R7 masked after reselect", d, 8'h0B);
        bus_wr(2'd0, 1'b1, 8'd8);
        bus_wr(2'd2, 1'b1, 8'hFF);
        check("R6 amplitude mask", img(8), 8'h1F);
        bus_wr(2'd0, 1'b1, 8'd6);
        bus_wr(2'd2, 1'b1, 8'hE7);
        check("R6 noise mask", img(6), 8'h07);
        bus_wr(2'd0, 1'b1, 8'd13);
        bus_wr(2'd2, 1'b1, 8'hF5);
        check("R6 shape mask", img(13), 8'h05);
        check("R9 strobe reg13", s_stb, 1'b1);
        bus_wr(2'd0, 1'b1, 8'd0);
        bus_wr(2'd2, 1'b1, 8'hFF);
        check("R6 unmasked reg0", img(0), 8'hFF);
    endtask

    task automatic t_out_of_range();
        logic [7:0] d;
        bus_wr(2'd0, 1'b1, 8'd3);
        bus_wr(2'd2, 1'b1, 8'h77);
        check("R6 coarse mask reg3", img(3), 8'h07);
        bus_wr(2'd0, 1'b1, 8'h13);
        bus_rd(2'd0, d);
        check("R1 0x13 not aliasing reg3 (read)", d, 8'hFF);
        bus_wr(2'd2, 1'b1, 8'h55);
        check("R2 no strobe out of range", s_stb, 1'b0);
        check("R1 reg3 untouched", img(3), 8'h07);
        bus_wr(2'd0, 1'b1, 8'h10);
        bus_wr(2'd2, 1'b0, 8'h5A);
        check("R2 reg0 untouched at 0x10", img(0), 8'hFF);
        bus_rd(2'd0, d);
        check("R2 read 0xFF at 0x10", d, 8'hFF);
    endtask

    task automatic t_alias();
        logic [7:0] d;
        bus_wr(2'd1, 1'b1, 8'd2);
        bus_wr(2'd3, 1'b1, 8'h42);
        check("R3 shadow byte write stored", img(2), 8'h42);
        bus_rd(2'd1, d); check("R4 read offset1", d, 8'hFF);
        bus_rd(2'd2, d); check("R4 read offset2", d, 8'hFF);
        bus_rd(2'd3, d); check("R4 read offset3", d, 8'hFF);
        bus_wr(2'd3, 1'b0, 8'h99);
        check("R5 wide shadow data dropped", img(2), 8'h42);
        check("R5 wide shadow no strobe", s_stb, 1'b0);
        bus_wr(2'd1, 1'b0, 8'd5);
        bus_rd(2'd0, d);
        check("R5 wide shadow select dropped", d, 8'h42);
        bus_wr(2'd2, 1'b0, 8'h11);
        check("R3 wide write at offset2", img(2), 8'h11);
    endtask

    task automatic t_port_regs();
        logic [7:0] d;
        bus_wr(2'd0, 1'b1, 8'd14);
        bus_wr(2'd2, 1'b1, 8'h3C);
        check("R9 no strobe reg14", s_stb, 1'b0);
        check("R11 image reg14", img(14), 8'h3C);
        bus_wr(2'd0, 1'b1, 8'd15);
        bus_wr(2'd2, 1'b1, 8'hC3);
        check("R9 no strobe reg15", s_stb, 1'b0);
        bus_rd(2'd0, d);
        check("R10 read value", d, 8'hC3);
        repeat (3) @(negedge clk);
        check("R10 rdata holds", rdata, 8'hC3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask_readback();
        t_out_of_range();
        t_alias();
        t_port_regs();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule